// File: doc/BRIEF.md
# Pulse-Per-Second Edge Capture Unit

This block watches one of two modem-status inputs (clear-to-send or carrier-detect) for a pulse-per-second reference and stamps each edge with the value of a free-running cycle counter. Software picks the input, can invert its sense, and can switch to a narrow-pulse mode. In normal mode, rising and falling edges of the conditioned level become separate ASSERT and CLEAR events, and each event carries its own timestamp. In narrow mode a sticky change latch catches pulses too short to be seen as two clean edges. Each latched change becomes an ASSERT/CLEAR pair that shares one timestamp. A programmable hold-off then suppresses further pairs for a fixed number of cycles, which defaults to half a second at 125 MHz.

Software reaches one read/write mode register and three read-only capture registers over a simple word bus. A one-cycle strobe with two flag bits reports every new event to nearby logic.

Top module: `pps_capture_top`

## Requirements
- R1: Address 0 holds the 8-bit mode byte and reads back the last value written. Bits [1:0] select the source: 0 = none, 1 = CTS, 2 = DCD, 3 = none. Bit 4 inverts the line sense. Bit 5 selects narrow-pulse mode.
- R2: After reset, all four addresses read zero and `evt_valid` is low.
- R3: In normal mode without inversion, a rising edge of the selected line is an ASSERT event and a falling edge is a CLEAR event. Take the first rising clock edge that samples the new line level as edge 1. On edge 3, `evt_valid` goes high for one cycle, with `evt_flags` bit 0 set for ASSERT and bit 1 set for CLEAR.
- R4: With bit 4 set, a low line level counts as asserted: a falling edge gives ASSERT and a rising edge gives CLEAR.
- R5: A change on the line that is not selected never produces an event. A change on any line while the source field is 0 or 3 never produces an event.
- R6: Each ASSERT loads a free-running 32-bit cycle count into the register at address 1. Each CLEAR loads it into the register at address 2. Two events whose input changes lie N cycles apart hold timestamps that differ by N.
- R7: Address 3 holds the ASSERT event count in bits [15:0] and the CLEAR event count in bits [31:16]. Each count rises by one per event and wraps at 2^SEQ_W.
- R8: In narrow mode, any change on the selected line is latched. On the fourth rising edge, counting as R3 does, the latch yields one event with both flag bits set. Both counts advance and both timestamps become equal.
- R9: After a narrow-mode pair, line changes during the next LOCKOUT_CYCLES cycles produce no event. A change after that window produces a new pair.
- R10: A write to address 0 produces no event, even when it changes the source or the sense. It also clears the change latch and ends any running hold-off.
- R11: Writes to addresses 1, 2 and 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cts_in | input | 1 | Clear-to-send line, asynchronous |
| dcd_in | input | 1 | Carrier-detect line, asynchronous |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_valid | output | 1 | One-cycle strobe for a new event |
| evt_flags | output | 2 | Bit 0 = ASSERT, bit 1 = CLEAR, valid with `evt_valid` |

## Verification
The assertions assume that mode writes come as single-cycle strobes. They also assume that the hold-off is never reloaded while it is running, since a pair can only form after the hold-off reaches zero. The stimulus meets these assumptions: it changes the lines only at falling clock edges, and it writes the mode byte only while the lines are stable. Pulses in the narrow-mode checks are one clock wide. They are spaced either well inside or well outside a 40-cycle hold-off, so no change lands on the boundary cycle.

// File: rtl/pps_cap_pkg.sv
package pps_cap_pkg;

  // source selector field of the mode byte
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_CTS  = 2'd1,
    SRC_DCD  = 2'd2,
    SRC_RSV  = 2'd3
  } pps_src_e;

  // mode byte, bit 7 down to bit 0
  typedef struct packed {
    logic [1:0] rsv_hi;
    logic       narrow;
    logic       invert;
    logic [1:0] rsv_lo;
    pps_src_e   src;
  } pps_mode_t;

  localparam int unsigned MODE_W = $bits(pps_mode_t);

  // word addresses
  localparam logic [1:0] ADR_MODE  = 2'd0;
  localparam logic [1:0] ADR_TS_AS = 2'd1;
  localparam logic [1:0] ADR_TS_CL = 2'd2;
  localparam logic [1:0] ADR_SEQ   = 2'd3;

  // line indices on the synchronizer vector
  localparam int unsigned LN_CTS  = 0;
  localparam int unsigned LN_DCD  = 1;
  localparam int unsigned N_LINES = 2;

endpackage

// File: rtl/pps_line_sync.sv
module pps_line_sync #(
  parameter int unsigned N_IN   = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] raw_in,
  output logic [N_IN-1:0] sync_out
);

  for (genvar g = 0; g < N_IN; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], raw_in[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
      end else begin
        chain_q <= chain_d;
      end
    end

    assign sync_out[g] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/pps_event_gen.sv
module pps_event_gen
  import pps_cap_pkg::*;
#(
  parameter int unsigned LOCKOUT_CYCLES = 62_500_000,
  parameter int unsigned LOCK_W         = $clog2(LOCKOUT_CYCLES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] line_sync,
  input  pps_mode_t          mode,
  input  logic               mode_chg,
  output logic               fire_assert,
  output logic               fire_clear
);

  localparam logic [LOCK_W-1:0] LOCK_LOAD = LOCK_W'(LOCKOUT_CYCLES);

  logic              prev_q, prev_d;
  logic              delta_q, delta_d;
  logic              resync_q, resync_d;
  logic [LOCK_W-1:0] lock_q, lock_d;

  logic src_on;
  logic sel_line;
  logic level;
  logic quiet;
  logic changed;
  logic fire_pair;
  logic lock_idle;
  logic mode_unused;

  assign mode_unused = ^{mode.rsv_hi, mode.rsv_lo};

  // source selection and sense
  always_comb begin
    src_on   = 1'b0;
    sel_line = 1'b0;
    unique case (mode.src)
      SRC_CTS: begin src_on = 1'b1; sel_line = line_sync[LN_CTS]; end
      SRC_DCD: begin src_on = 1'b1; sel_line = line_sync[LN_DCD]; end
      default: begin src_on = 1'b0; sel_line = 1'b0; end
    endcase
  end

  assign level     = src_on & (sel_line ^ mode.invert);
  assign quiet     = mode_chg | resync_q;
  assign changed   = src_on & (level != prev_q);
  assign lock_idle = (lock_q == '0);
  assign fire_pair = mode.narrow & delta_q & ~quiet;

  // event decode
  always_comb begin
    fire_assert = 1'b0;
    fire_clear  = 1'b0;
    if (mode.narrow) begin
      fire_assert = fire_pair;
      fire_clear  = fire_pair;
    end else if (changed && !quiet) begin
      fire_assert = level;
      fire_clear  = ~level;
    end
  end

  // next state
  always_comb begin
    prev_d   = level;
    resync_d = mode_chg;

    delta_d = delta_q;
    if (mode_chg || fire_pair) begin
      delta_d = 1'b0;
    end else if (mode.narrow && changed && lock_idle && !resync_q) begin
      delta_d = 1'b1;
    end

    lock_d = lock_q;
    if (mode_chg) begin
      lock_d = '0;
    end else if (fire_pair) begin
      lock_d = LOCK_LOAD;
    end else if (!lock_idle) begin
      lock_d = lock_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      delta_q  <= 1'b0;
      resync_q <= 1'b0;
      lock_q   <= '0;
    end else begin
      prev_q   <= prev_d;
      delta_q  <= delta_d;
      resync_q <= resync_d;
      lock_q   <= lock_d;
    end
  end

  // R9
  lock_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q != '0) |-> !(fire_assert || fire_clear));

  // R9
  lock_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q != '0 && !mode_chg) |=> (lock_q == $past(lock_q) - 1'b1));

  // R8
  pair_loads_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_assert && fire_clear) |=> (lock_q == LOCK_LOAD));

  // R10
  chg_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (lock_q == '0 && !delta_q));

endmodule

// File: rtl/pps_capture_regs.sv
module pps_capture_regs
  import pps_cap_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TS_W   = 32,
  parameter int unsigned SEQ_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              fire_assert,
  input  logic              fire_clear,
  output pps_mode_t         mode,
  output logic              mode_chg,
  output logic              evt_valid,
  output logic [1:0]        evt_flags
);

  localparam int unsigned HALF = DATA_W / 2;

  pps_mode_t         mode_q, mode_d;
  logic [TS_W-1:0]   ts_cnt_q, ts_cnt_d;
  logic [TS_W-1:0]   ts_as_q, ts_as_d;
  logic [TS_W-1:0]   ts_cl_q, ts_cl_d;
  logic [SEQ_W-1:0]  seq_as_q, seq_as_d;
  logic [SEQ_W-1:0]  seq_cl_q, seq_cl_d;
  logic              evt_q, evt_d;
  logic [1:0]        flags_q, flags_d;

  logic              mode_en;
  logic              as_en;
  logic              cl_en;
  logic              wdata_unused;

  assign wdata_unused = ^bus_wdata[DATA_W-1:MODE_W];

  // clock enables
  assign mode_en = bus_wr && (bus_addr == ADR_MODE);
  assign as_en   = fire_assert;
  assign cl_en   = fire_clear;

  // next state
  always_comb begin
    ts_cnt_d = ts_cnt_q + 1'b1;
    mode_d   = mode_en ? pps_mode_t'(bus_wdata[MODE_W-1:0]) : mode_q;
    ts_as_d  = as_en ? ts_cnt_q : ts_as_q;
    ts_cl_d  = cl_en ? ts_cnt_q : ts_cl_q;
    seq_as_d = as_en ? seq_as_q + 1'b1 : seq_as_q;
    seq_cl_d = cl_en ? seq_cl_q + 1'b1 : seq_cl_q;
    evt_d    = as_en | cl_en;
    flags_d  = {cl_en, as_en};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      ts_cnt_q <= '0;
      ts_as_q  <= '0;
      ts_cl_q  <= '0;
      seq_as_q <= '0;
      seq_cl_q <= '0;
      evt_q    <= 1'b0;
      flags_q  <= 2'b00;
    end else begin
      mode_q   <= mode_d;
      ts_cnt_q <= ts_cnt_d;
      ts_as_q  <= ts_as_d;
      ts_cl_q  <= ts_cl_d;
      seq_as_q <= seq_as_d;
      seq_cl_q <= seq_cl_d;
      evt_q    <= evt_d;
      flags_q  <= flags_d;
    end
  end

  // read mux
  always_comb begin
    unique case (bus_addr)
      ADR_MODE:  bus_rdata = DATA_W'(mode_q);
      ADR_TS_AS: bus_rdata = DATA_W'(ts_as_q);
      ADR_TS_CL: bus_rdata = DATA_W'(ts_cl_q);
      default:   bus_rdata = {HALF'(seq_cl_q), HALF'(seq_as_q)};
    endcase
  end

  assign mode      = mode_q;
  assign mode_chg  = mode_en;
  assign evt_valid = evt_q;
  assign evt_flags = flags_q;

  // R7
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_assert |=> (seq_as_q == $past(seq_as_q) + 1'b1));

  // R8
  pair_ts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q && flags_q == 2'b11) |-> (ts_as_q == ts_cl_q));

  // R10
  mode_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_en |=> !evt_q);

  // R11
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != ADR_MODE) |=> (mode_q == $past(mode_q)));

  // R6
  ts_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_cnt_q != '1) |=> (ts_cnt_q == $past(ts_cnt_q) + 1'b1));

endmodule

// File: rtl/pps_capture_top.sv
module pps_capture_top
  import pps_cap_pkg::*;
#(
  parameter int unsigned DATA_W         = 32,
  parameter int unsigned TS_W           = 32,
  parameter int unsigned SEQ_W          = 16,
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned LOCKOUT_CYCLES = 62_500_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cts_in,
  input  logic              dcd_in,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              evt_valid,
  output logic [1:0]        evt_flags
);

  localparam int unsigned LOCK_W = $clog2(LOCKOUT_CYCLES + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_n_int = rst_pipe_q[1];

  logic [N_LINES-1:0] raw_lines;
  logic [N_LINES-1:0] sync_lines;
  pps_mode_t          mode;
  logic               mode_chg;
  logic               fire_assert;
  logic               fire_clear;

  assign raw_lines[LN_CTS] = cts_in;
  assign raw_lines[LN_DCD] = dcd_in;

  pps_line_sync #(
    .N_IN   (N_LINES),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .raw_in   (raw_lines),
    .sync_out (sync_lines)
  );

  pps_event_gen #(
    .LOCKOUT_CYCLES (LOCKOUT_CYCLES),
    .LOCK_W         (LOCK_W)
  ) u_evt (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .line_sync   (sync_lines),
    .mode        (mode),
    .mode_chg    (mode_chg),
    .fire_assert (fire_assert),
    .fire_clear  (fire_clear)
  );

  pps_capture_regs #(
    .DATA_W (DATA_W),
    .TS_W   (TS_W),
    .SEQ_W  (SEQ_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .fire_assert (fire_assert),
    .fire_clear  (fire_clear),
    .mode        (mode),
    .mode_chg    (mode_chg),
    .evt_valid   (evt_valid),
    .evt_flags   (evt_flags)
  );

endmodule

// File: tb/sim_pps_capture_top.sv
module sim_pps_capture_top;

  localparam int unsigned SEQ_W = 4;
  localparam int unsigned LOCK  = 40;
  localparam int          SMASK = (1 << SEQ_W) - 1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cts, dcd, wr;
  logic [1:0]  addr;
  logic [31:0] wdata, rdata;
  logic        ev;
  logic [1:0]  fl;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  int exp_a = 0;
  int exp_c = 0;

  always #4 clk = ~clk;

  pps_capture_top #(
    .SEQ_W          (SEQ_W),
    .LOCKOUT_CYCLES (LOCK)
  ) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .cts_in    (cts),
    .dcd_in    (dcd),
    .bus_wr    (wr),
    .bus_addr  (addr),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .evt_valid (ev),
    .evt_flags (fl)
  );

  // {mode byte, cts, dcd, expected flags}
  localparam logic [11:0] VEC [15] = '{
    {8'h00, 1'b1, 1'b0, 2'b00},
    {8'h01, 1'b1, 1'b0, 2'b00},
    {8'h01, 1'b0, 1'b0, 2'b10},
    {8'h01, 1'b1, 1'b0, 2'b01},
    {8'h01, 1'b1, 1'b1, 2'b00},
    {8'h02, 1'b1, 1'b1, 2'b00},
    {8'h02, 1'b0, 1'b1, 2'b00},
    {8'h02, 1'b0, 1'b0, 2'b10},
    {8'h12, 1'b0, 1'b0, 2'b00},
    {8'h12, 1'b0, 1'b1, 2'b10},
    {8'h12, 1'b0, 1'b0, 2'b01},
    {8'h11, 1'b0, 1'b0, 2'b00},
    {8'h11, 1'b1, 1'b0, 2'b10},
    {8'h03, 1'b0, 1'b0, 2'b00},
    {8'h00, 1'b1, 1'b0, 2'b00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    addr  = a;
    wdata = d;
    wr    = 1'b1;
    @(negedge clk);
    wr    = 1'b0;
  endtask

  function automatic logic [31:0] seq_word();
    return {16'(exp_c & SMASK), 16'(exp_a & SMASK)};
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d, t1, t2, sv;
    logic [7:0]  cur_mode;
    string       tag;
    rst_n = 1'b0; cts = 1'b0; dcd = 1'b0; wr = 1'b0; addr = 2'd0; wdata = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R2 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R2 reset register", d, 32'h0);
    end
    chk("R2 reset strobe", {31'b0, ev}, 32'h0);

    // vector table: normal mode edges, sense and source selection
    cur_mode = 8'h00;
    for (int i = 0; i < 15; i++) begin
      logic [7:0] vm;
      logic [1:0] vf;
      vm = VEC[i][11:4];
      vf = VEC[i][1:0];
      if (vm != cur_mode) begin
        wr_reg(2'd0, {24'b0, vm});
        cur_mode = vm;
        for (int k = 0; k < 4; k++) begin
          chk("R10 mode write quiet", {31'b0, ev}, 32'h0);
          tick(1);
        end
        rd(2'd0, d);
        chk("R1 mode readback", d, {24'b0, vm});
      end
      if (vf == 2'b00)    tag = "R5 no event";
      else if (vm[4])     tag = "R4 inverted edge";
      else                tag = "R3 plain edge";
      cts = VEC[i][3];
      dcd = VEC[i][2];
      tick(2);
      chk({tag, " early"}, {31'b0, ev}, 32'h0);
      tick(1);
      chk(tag, {29'b0, ev, fl}, {29'b0, |vf, vf});
      tick(1);
      chk({tag, " one cycle"}, {31'b0, ev}, 32'h0);
      if (vf[0]) exp_a++;
      if (vf[1]) exp_c++;
    end
    rd(2'd3, d);
    chk("R7 counts after table", d, seq_word());

    // R6 timestamp spacing: clear then assert ten cycles later
    wr_reg(2'd0, 32'h01);
    tick(3);
    cts = 1'b0;
    tick(10);
    cts = 1'b1;
    tick(4);
    exp_c++; exp_a++;
    rd(2'd1, t1);
    rd(2'd2, t2);
    chk("R6 timestamp spacing", t1 - t2, 32'd10);

    // R8 narrow pulse produces a pair with shared timestamp
    wr_reg(2'd0, 32'h21);
    tick(3);
    cts = 1'b0;
    tick(1);
    cts = 1'b1;
    tick(2);
    chk("R8 narrow early", {31'b0, ev}, 32'h0);
    tick(1);
    chk("R8 narrow pair flags", {29'b0, ev, fl}, 32'h7);
    exp_a++; exp_c++;
    rd(2'd1, t1);
    rd(2'd2, t2);
    chk("R8 equal timestamps", t1, t2);
    rd(2'd3, d);
    chk("R8 both counts", d, seq_word());

    // R9 pulse inside hold-off is dropped
    tick(8);
    cts = 1'b0;
    tick(1);
    cts = 1'b1;
    tick(6);
    rd(2'd3, d);
    chk("R9 suppressed in hold-off", d, seq_word());
    rd(2'd1, d);
    chk("R9 timestamp kept", d, t1);

    // R9 pulse after hold-off is accepted
    tick(40);
    cts = 1'b0;
    tick(1);
    cts = 1'b1;
    tick(3);
    chk("R9 pair after hold-off", {29'b0, ev, fl}, 32'h7);
    exp_a++; exp_c++;

    // R10 rewriting mode ends the hold-off
    tick(2);
    wr_reg(2'd0, 32'h21);
    tick(3);
    cts = 1'b0;
    tick(1);
    cts = 1'b1;
    tick(3);
    chk("R10 hold-off cleared", {29'b0, ev, fl}, 32'h7);
    exp_a++; exp_c++;
    rd(2'd3, d);
    chk("R10 counts", d, seq_word());

    // R11 writes to capture registers are ignored
    rd(2'd1, t1);
    rd(2'd3, sv);
    wr_reg(2'd1, 32'hFFFF_FFFF);
    wr_reg(2'd3, 32'hA5A5_A5A5);
    wr_reg(2'd2, 32'h0000_0013);
    rd(2'd1, d);
    chk("R11 assert ts untouched", d, t1);
    rd(2'd3, d);
    chk("R11 counts untouched", d, sv);
    rd(2'd0, d);
    chk("R11 mode untouched", d, 32'h21);

    // R7 counter wrap under repeated edges
    wr_reg(2'd0, 32'h01);
    tick(3);
    for (int k = 0; k < 36; k++) begin
      cts = ~cts;
      tick(4);
      if (cts) exp_a++;
      else     exp_c++;
    end
    rd(2'd3, d);
    chk("R7 wrapped counts", d, seq_word());

    finish_run();
  end

endmodule